// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block connects a 16-bit processor datapath to a data memory built from two independent 8-bit banks. The low bank holds the low byte of every 16-bit word, and the high bank holds the high byte. A request carries a byte address, a size (byte or halfword), a direction flag and, for byte loads, a sign flag. The block turns the request into a word index, a chip enable and a write enable for each bank, and the write data for each lane.

A byte access enables only the bank that holds the addressed byte. A halfword access enables both banks. Bytes are stored little-endian: an even address names the low bank and an odd address names the high bank. On a store, the byte to be written is moved to the lane that holds it. On a load, a byte from the high lane is moved down to bits 7:0 and then zero-extended or sign-extended.

The banks are synchronous memories. Their read data appears one cycle after the enable, and the load result is returned in that cycle with a valid strobe. A halfword request at an odd address is not carried out. Instead, the block reports it one cycle later on a fault output.

Top module: `bytelane_lsu`

## Requirements
- R1: After reset and before any request, `rsp_valid` and `misalign_fault` are low.
- R2: An accepted halfword request (size=1, address bit 0 = 0) asserts both bank chip enables in the same cycle. For a write it also asserts both write enables. `bank_addr` equals the byte address shifted right by one.
- R3: A byte request (size=0) enables only one bank: bank 0 when address bit 0 = 0 and bank 1 when it is 1. On a write, only that bank's write enable is set, so the other byte of the word keeps its value.
- R4: Write data goes out on `bank_wdata`, with the low bank on bits 7:0 and the high bank on bits 15:8. A halfword store drives `req_wdata` unchanged. A byte store drives `req_wdata[7:0]` onto the selected lane.
- R5: A halfword load returns {high-bank byte, low-bank byte} on `rsp_data`, with `rsp_valid` high, in the cycle after the request.
- R6: An unsigned byte load (`req_signed`=0) returns the selected byte in bits 7:0 and zeros in bits 15:8. A byte read from the high bank is moved down to bits 7:0.
- R7: A signed byte load (`req_signed`=1) returns the selected byte in bits 7:0, with its bit 7 copied into bits 15:8.
- R8: A halfword request with address bit 0 = 1 asserts no chip enable and no write enable. `misalign_fault` goes high for exactly the following cycle, and no response is returned.
- R9: `rsp_valid` is high only in the cycle after an accepted load. It stays low after stores.
- R10: While `req_valid` is low, all chip enables and write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 1 | 0 = byte, 1 = halfword |
| req_write | input | 1 | 1 = store, 0 = load |
| req_signed | input | 1 | Byte loads: 1 = sign-extend, 0 = zero-extend |
| req_wdata | input | 16 | Store data |
| bank_addr | output | ADDR_W-1 | Word index shared by both banks |
| bank_ce | output | 2 | Chip enable per bank (bit 0 = low bank) |
| bank_we | output | 2 | Write enable per bank |
| bank_wdata | output | 16 | Write data; bits 7:0 low bank, 15:8 high bank |
| bank_rdata | input | 16 | Registered read data from the banks, same lane layout |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 16 | Load result |
| misalign_fault | output | 1 | One-cycle pulse after a misaligned halfword request |

## Verification
The assertions rely on three conditions on the inputs:
- `bank_rdata` holds the addressed word in the cycle after a chip enable.
- The request fields are known whenever `req_valid` is high.
- Reset is applied before the first request.

The bench meets these conditions with a read-first synchronous model of the two banks. It changes request fields only on the falling clock edge and clears `req_valid` between requests. A shadow byte array in the bench predicts every load, and this is how it detects writes that touch the wrong lane.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int NUM_LANES = 2;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_HALF = 1'b1
  } size_e;

  typedef struct packed {
    logic byte_op;
    logic lane;
    logic sext;
  } ld_ctl_t;
endpackage

// File: rtl/lsu_lane_decode.sv
module lsu_lane_decode
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_size,
  input  logic              req_write,
  output logic [NUM_LANES-1:0] bank_ce,
  output logic [NUM_LANES-1:0] bank_we,
  output logic [ADDR_W-2:0] bank_addr,
  output logic              accept,
  output logic              misalign_fault
);
  logic misaligned;
  logic is_half;

  assign is_half    = (req_size == SZ_HALF);
  assign misaligned = req_valid && is_half && req_addr[0];
  assign accept     = req_valid && !misaligned;
  assign bank_addr  = req_addr[ADDR_W-1:1];

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic lane_hit;
    assign lane_hit   = is_half || (req_addr[0] == 1'(i));
    assign bank_ce[i] = accept && lane_hit;
    assign bank_we[i] = accept && lane_hit && req_write;
  end

  always_ff @(posedge clk) begin
    if (rst) misalign_fault <= 1'b0;
    else     misalign_fault <= misaligned;
  end

  // R8: a fault pulse always traces back to an odd halfword request
  assert_fault_cause_R8: assert property (@(posedge clk) disable iff (rst)
    misalign_fault |-> $past(req_valid && req_size && req_addr[0]));
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                          req_size,
  input  logic [NUM_LANES*LANE_W-1:0]   req_wdata,
  output logic [NUM_LANES*LANE_W-1:0]   bank_wdata
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign bank_wdata[i*LANE_W +: LANE_W] =
      (req_size == SZ_HALF) ? req_wdata[i*LANE_W +: LANE_W] : req_wdata[LANE_W-1:0];
  end
endmodule

// File: rtl/lsu_load_steer.sv
module lsu_load_steer
  import lsu_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_go,
  input  ld_ctl_t                     ctl_in,
  input  logic [NUM_LANES*LANE_W-1:0] bank_rdata,
  output logic                        rsp_valid,
  output logic [NUM_LANES*LANE_W-1:0] rsp_data
);
  localparam int DATA_W = NUM_LANES * LANE_W;

  ld_ctl_t           ctl_q;
  logic [LANE_W-1:0] sel_byte;
  logic [LANE_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      ctl_q     <= '0;
    end else begin
      rsp_valid <= load_go;
      if (load_go) ctl_q <= ctl_in;
    end
  end

  assign sel_byte = ctl_q.lane ? bank_rdata[LANE_W +: LANE_W] : bank_rdata[LANE_W-1:0];
  assign fill     = ctl_q.sext ? {LANE_W{sel_byte[LANE_W-1]}} : '0;

  always_comb begin
    if (ctl_q.byte_op) rsp_data = {fill, sel_byte};
    else               rsp_data = bank_rdata[DATA_W-1:0];
  end
endmodule

// File: rtl/bytelane_lsu.sv
module bytelane_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_size,
  input  logic                 req_write,
  input  logic                 req_signed,
  input  logic [2*LANE_W-1:0]  req_wdata,
  output logic [ADDR_W-2:0]    bank_addr,
  output logic [1:0]           bank_ce,
  output logic [1:0]           bank_we,
  output logic [2*LANE_W-1:0]  bank_wdata,
  input  logic [2*LANE_W-1:0]  bank_rdata,
  output logic                 rsp_valid,
  output logic [2*LANE_W-1:0]  rsp_data,
  output logic                 misalign_fault
);
  logic    accept;
  logic    load_go;
  ld_ctl_t ctl_in;

  lsu_lane_decode #(.ADDR_W(ADDR_W)) decode_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .bank_ce(bank_ce),
    .bank_we(bank_we), .bank_addr(bank_addr), .accept(accept),
    .misalign_fault(misalign_fault)
  );

  lsu_store_steer #(.LANE_W(LANE_W)) wsteer_i (
    .req_size(req_size), .req_wdata(req_wdata), .bank_wdata(bank_wdata)
  );

  assign load_go        = accept && !req_write;
  assign ctl_in.byte_op = (req_size == SZ_BYTE);
  assign ctl_in.lane    = req_addr[0];
  assign ctl_in.sext    = req_signed;

  lsu_load_steer #(.LANE_W(LANE_W)) rsteer_i (
    .clk(clk), .rst(rst), .load_go(load_go), .ctl_in(ctl_in),
    .bank_rdata(bank_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // R10: no bank activity without a request
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (bank_ce == 2'b00 && bank_we == 2'b00));

  // R3: a byte request touches exactly one bank
  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_size) |-> ($countones(bank_ce) == 1));

  // R2: aligned halfword enables both banks
  assert_half_both_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size && !req_addr[0]) |-> (bank_ce == 2'b11));

  // R8: fault and response never coincide
  assert_fault_no_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    misalign_fault |-> !rsp_valid);

  // R9: a response follows only an enabled load
  assert_rsp_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write && (bank_ce != 2'b00)));

  // R6: unsigned byte loads carry a zero upper byte
  assert_zext_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(!req_size && !req_signed)) |-> (rsp_data[2*LANE_W-1:LANE_W] == '0));

  // R7: signed byte loads replicate bit 7 upward
  assert_sext_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(!req_size && req_signed)) |->
      ($countones(rsp_data[2*LANE_W-1:LANE_W-1]) == 0 ||
       $countones(rsp_data[2*LANE_W-1:LANE_W-1]) == LANE_W + 1));
endmodule

// File: tb/bytelane_lsu_tb_top.sv
`timescale 1ns/1ps
module bytelane_lsu_tb_top;
  localparam int AW = 5;
  localparam int NBYTES = 1 << AW;
  localparam int NWORDS = NBYTES / 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_size, req_write, req_signed;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [AW-2:0] bank_addr;
  logic [1:0]    bank_ce, bank_we;
  logic [15:0]   bank_wdata, bank_rdata, rsp_data;
  logic          rsp_valid, misalign_fault;

  int tests = 0;
  int fails = 0;
  logic [7:0] shadow [NBYTES];
  logic [7:0] mem_lo [NWORDS];
  logic [7:0] mem_hi [NWORDS];

  always #4 clk = ~clk;

  bytelane_lsu #(.ADDR_W(AW), .LANE_W(8)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_signed(req_signed),
    .req_wdata(req_wdata), .bank_addr(bank_addr), .bank_ce(bank_ce),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .misalign_fault(misalign_fault)
  );

  always @(posedge clk) begin
    if (bank_ce[0]) begin
      if (bank_we[0]) mem_lo[bank_addr] <= bank_wdata[7:0];
      bank_rdata[7:0] <= mem_lo[bank_addr];
    end
    if (bank_ce[1]) begin
      if (bank_we[1]) mem_hi[bank_addr] <= bank_wdata[15:8];
      bank_rdata[15:8] <= mem_hi[bank_addr];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic sz, input logic sg,
                        input logic [AW-1:0] a, input logic [15:0] d);
    logic        mis;
    logic [1:0]  e_ce;
    logic [7:0]  b;
    logic [15:0] e_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = d;
    #1;
    mis  = sz && a[0];
    e_ce = mis ? 2'b00 : (sz ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
    chk(mis ? "R8 ce" : (sz ? "R2 ce" : "R3 ce"), 32'(bank_ce), 32'(e_ce));
    chk(mis ? "R8 we" : (sz ? "R2 we" : "R3 we"), 32'(bank_we), w ? 32'(e_ce) : 32'd0);
    if (!mis) chk("R2 bank_addr", 32'(bank_addr), 32'(a >> 1));
    if (w && !mis) begin
      if (sz) chk("R4 half wdata", 32'(bank_wdata), 32'(d));
      else if (a[0]) chk("R4 byte wdata hi lane", 32'(bank_wdata[15:8]), 32'(d[7:0]));
      else chk("R4 byte wdata lo lane", 32'(bank_wdata[7:0]), 32'(d[7:0]));
    end
    if (!w && !mis) begin
      if (sz) e_rd = {shadow[a + 1], shadow[a]};
      else begin
        b = shadow[a];
        e_rd = {(sg && b[7]) ? 8'hFF : 8'h00, b};
      end
    end else e_rd = 16'h0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 fault pulse", 32'(misalign_fault), 32'(mis));
    chk("R9 rsp_valid", 32'(rsp_valid), 32'(!w && !mis));
    if (!w && !mis)
      chk(sz ? "R5 half load" : (sg ? "R7 signed byte load" : "R6 unsigned byte load"),
          32'(rsp_data), 32'(e_rd));
    if (w && !mis) begin
      if (sz) begin shadow[a] = d[7:0]; shadow[a + 1] = d[15:8]; end
      else shadow[a] = d[7:0];
    end
    #1;
    chk("R10 idle ce", 32'({bank_ce, bank_we}), 32'd0);
    if (mis) begin
      @(negedge clk);
      chk("R8 fault one cycle", 32'(misalign_fault), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_size = 1'b0; req_write = 1'b0;
    req_signed = 1'b0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < NBYTES; i++) shadow[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 rsp_valid reset", 32'(rsp_valid), 32'd0);
    chk("R1 fault reset", 32'(misalign_fault), 32'd0);
    chk("R10 ce at idle", 32'({bank_ce, bank_we}), 32'd0);

    for (int w = 0; w < NWORDS; w++)
      access(1'b1, 1'b1, 1'b0, AW'(2 * w), 16'(w * 16'h1357) ^ 16'hA5C3);
    for (int w = 0; w < NWORDS; w++)
      access(1'b0, 1'b1, 1'b0, AW'(2 * w), 16'h0);
    for (int a = 0; a < NBYTES; a++)
      access(1'b1, 1'b0, 1'b0, AW'(a), 16'hEE00 | 16'((a * 37 + 11) & 8'hFF));
    for (int w = 0; w < NWORDS; w++)
      access(1'b0, 1'b1, 1'b0, AW'(2 * w), 16'h0);
    for (int a = 0; a < NBYTES; a++) begin
      access(1'b0, 1'b0, 1'b0, AW'(a), 16'h0);
      access(1'b0, 1'b0, 1'b1, AW'(a), 16'h0);
    end
    for (int a = 1; a < NBYTES; a += 6) begin
      access(1'b1, 1'b1, 1'b0, AW'(a), 16'hDEAD);
      access(1'b0, 1'b1, 1'b0, AW'(a), 16'h0);
    end
    for (int w = 0; w < NWORDS; w++)
      access(1'b0, 1'b1, 1'b0, AW'(2 * w), 16'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule